// File: doc/BRIEF.md
# Multifunction 32-bit Arithmetic/Logic Unit

A purely combinational arithmetic/logic unit for a processor datapath. Two 32-bit operands `x_i` and `y_i` enter together with eight control bits: a 2-bit function class, one add/subtract bit, three shifter-control bits and a 2-bit logic select. The block returns a 32-bit result with an overflow flag and a zero flag in the same cycle.

Internally, one two's-complement adder serves both add and subtract. For subtract it inverts `y_i` and forces a carry-in of 1. The same adder also produces the signed less-than answer. A four-function logic unit and a five-stage barrel shifter work in parallel with the adder. A final multiplexer selects the active unit's output by function class.

The shifter always moves `y_i`. Its distance comes either from the `shamt_i` port or from the five low bits of `x_i`.

Top module: `alu_multifunc`

## Requirements
- R1: `fclass_i` selects the result source: 2'b00 shifter, 2'b01 set-less-than, 2'b10 adder, 2'b11 logic unit.
- R2: In the logic class, `logic_sel_i` selects the function: 2'b00 gives x AND y, 2'b01 gives x OR y, 2'b10 gives x XOR y, 2'b11 gives NOT(x OR y).
- R3: In the arithmetic class, `sub_i`=0 yields x+y and `sub_i`=1 yields x-y, both modulo 2^32.
- R4: In the arithmetic class, `ovf_o` is 1 exactly when the signed result of the selected operation cannot be represented in 32 bits.
- R5: `ovf_o` is 0 in the shift, set-less-than and logic classes, whatever the operands.
- R6: In the set-less-than class, the result is 32'd1 when x is less than y as signed numbers and 32'd0 otherwise. This holds for either value of `sub_i` and when x-y overflows.
- R7: In the shift class, `shift_ctl_i[1:0]` selects the shift kind, and the shifted operand is y. 2'b00 is logical left. 2'b01 passes y unchanged. 2'b10 is logical right with zero fill. 2'b11 is arithmetic right, which fills with y[31].
- R8: `shift_ctl_i[2]`=0 takes the shift distance from `shamt_i`; `shift_ctl_i[2]`=1 takes it from `x_i[4:0]`.
- R9: `zero_o` is 1 exactly when all 32 result bits are 0, in every class.
- R10: A shift distance of 0 returns y unchanged for every shift kind. A distance of 31 leaves only one original bit of y, or 32 copies of y[31] for an arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 32 | First operand; low 5 bits can supply the shift distance |
| y_i | input | 32 | Second operand; the shifter's data input |
| shamt_i | input | 5 | Constant shift distance |
| fclass_i | input | 2 | Function class select |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| shift_ctl_i | input | 3 | [2] distance source, [1:0] shift kind |
| logic_sel_i | input | 2 | Logic function select |
| result_o | output | 32 | Selected result |
| ovf_o | output | 1 | Signed overflow of the arithmetic class |
| zero_o | output | 1 | Result is all zeros |

## Verification
No registers lie on any path, so result, overflow and zero are all due in the same cycle the operands and controls are applied. The bench drives every new vector on the falling clock edge. It samples the outputs one nanosecond later, so the combinational logic has settled and no rising edge falls between stimulus and sample. Each sampled value is compared against a reference function that computes the same vector in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FC_SHIFT = 2'b00,
    FC_SLT   = 2'b01,
    FC_ARITH = 2'b10,
    FC_LOGIC = 2'b11
  } fclass_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOR = 2'b11
  } logic_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_PASS  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_ARITH = 2'b11
  } shift_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_o
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    // signed less-than from difference sign corrected by overflow
    lt_o  = sum_o[W-1] ^ ovf_o;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (logic_e'(sel_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   d_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [1:0]     kind_i,
  output logic [W-1:0]   res_o
);
  logic         left;
  logic         fill;
  logic [W-1:0] d_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stg [SHW+1];

  assign left = (shift_e'(kind_i) == SH_LEFT);
  assign fill = (shift_e'(kind_i) == SH_ARITH) & d_i[W-1];

  // left shift reuses the right-shift chain on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign d_rev[i]   = d_i[W-1-i];
    assign out_rev[i] = stg[SHW][W-1-i];
  end

  assign stg[0] = left ? d_rev : d_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  always_comb begin
    unique case (shift_e'(kind_i))
      SH_PASS: res_o = d_i;
      SH_LEFT: res_o = out_rev;
      default: res_o = stg[SHW];
    endcase
  end
endmodule

// File: rtl/alu_multifunc.sv
module alu_multifunc
  import alu_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [1:0]     fclass_i,
  input  logic           sub_i,
  input  logic [2:0]     shift_ctl_i,
  input  logic [1:0]     logic_sel_i,
  output logic [W-1:0]   result_o,
  output logic           ovf_o,
  output logic           zero_o
);
  logic           sub_eff;
  logic [W-1:0]   sum;
  logic           add_ovf;
  logic           lt;
  logic [W-1:0]   lg_res;
  logic [W-1:0]   sh_res;
  logic [SHW-1:0] sh_amt;

  // less-than always needs a subtraction
  assign sub_eff = sub_i | (fclass_e'(fclass_i) == FC_SLT);
  assign sh_amt  = shift_ctl_i[2] ? x_i[SHW-1:0] : shamt_i;

  alu_addsub #(.W(W)) i_addsub (
    .a_i   (x_i),
    .b_i   (y_i),
    .sub_i (sub_eff),
    .sum_o (sum),
    .ovf_o (add_ovf),
    .lt_o  (lt)
  );

  alu_logic #(.W(W)) i_logic (
    .a_i   (x_i),
    .b_i   (y_i),
    .sel_i (logic_sel_i),
    .res_o (lg_res)
  );

  alu_shifter #(.W(W)) i_shifter (
    .d_i    (y_i),
    .amt_i  (sh_amt),
    .kind_i (shift_ctl_i[1:0]),
    .res_o  (sh_res)
  );

  always_comb begin
    ovf_o = 1'b0;
    unique case (fclass_e'(fclass_i))
      FC_SHIFT: result_o = sh_res;
      FC_SLT:   result_o = {{(W-1){1'b0}}, lt};
      FC_ARITH: begin
        result_o = sum;
        ovf_o    = add_ovf;
      end
      default:  result_o = lg_res;
    endcase
    zero_o = ~|result_o;
  end
endmodule

// File: rtl/alu_multifunc_chk.sv
module alu_multifunc_chk #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input logic [W-1:0]   x_i,
  input logic [W-1:0]   y_i,
  input logic [SHW-1:0] shamt_i,
  input logic [1:0]     fclass_i,
  input logic           sub_i,
  input logic [2:0]     shift_ctl_i,
  input logic [1:0]     logic_sel_i,
  input logic [W-1:0]   result_o,
  input logic           ovf_o,
  input logic           zero_o
);
  logic [SHW-1:0] amt;
  assign amt = shift_ctl_i[2] ? x_i[SHW-1:0] : shamt_i;

  always_comb begin
    if (fclass_i != 2'b10)
      p_no_overflow_r5: assert (!ovf_o);
    if (fclass_i == 2'b01)
      p_slt_bool_r6: assert (result_o[W-1:1] == '0);
    if (fclass_i == 2'b10 && !sub_i && y_i == '0)
      p_add_zero_r3: assert (result_o == x_i && !ovf_o);
    if (fclass_i == 2'b11 && logic_sel_i == 2'b00 && x_i == y_i)
      p_and_idem_r2: assert (result_o == x_i);
    if (fclass_i == 2'b00 && amt == '0)
      p_shift_zero_r10: assert (result_o == y_i);
    if (fclass_i == 2'b00 && shift_ctl_i[1:0] == 2'b11 && y_i[W-1])
      p_sra_sign_r7: assert (result_o[W-1]);
    if (zero_o)
      p_zero_flag_r9: assert (result_o == '0);
  end
endmodule

bind alu_multifunc alu_multifunc_chk #(.W(W)) i_chk (.*);

// File: tb/test_alu_multifunc.sv
module test_alu_multifunc;
  logic        clk;
  logic        rst_ni;
  logic [31:0] x_i, y_i;
  logic [4:0]  shamt_i;
  logic [1:0]  fclass_i;
  logic        sub_i;
  logic [2:0]  shift_ctl_i;
  logic [1:0]  logic_sel_i;
  logic [31:0] result_o;
  logic        ovf_o;
  logic        zero_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  alu_multifunc i_alu_multifunc (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [32:0] ref_alu(
      input logic [31:0] x, input logic [31:0] y, input logic [4:0] sa,
      input logic [1:0] fc, input logic sb, input logic [2:0] sc, input logic [1:0] ls);
    logic [31:0] r;
    logic        v;
    logic [4:0]  a;
    longint      sx, sy, ex;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    a = sc[2] ? x[4:0] : sa;
    v = 0;
    case (fc)
      2'b00: case (sc[1:0])
        2'b00: r = y << a;
        2'b01: r = y;
        2'b10: r = y >> a;
        default: r = 32'($signed(y) >>> a);
      endcase
      2'b01: r = (sx < sy) ? 32'd1 : 32'd0;
      2'b10: begin
        ex = sb ? sx - sy : sx + sy;
        r = 32'(ex);
        v = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
      end
      default: case (ls)
        2'b00: r = x & y;
        2'b01: r = x | y;
        2'b10: r = x ^ y;
        default: r = ~(x | y);
      endcase
    endcase
    return {v, r};
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [4:0] sa,
                       input logic [1:0] fc, input logic sb, input logic [2:0] sc,
                       input logic [1:0] ls, input string req);
    logic [32:0] e;
    @(negedge clk);
    x_i = x; y_i = y; shamt_i = sa; fclass_i = fc; sub_i = sb;
    shift_ctl_i = sc; logic_sel_i = ls;
    #1;
    e = ref_alu(x, y, sa, fc, sb, sc, ls);
    n_chk++;
    if (result_o !== e[31:0] || ovf_o !== e[32] || zero_o !== (e[31:0] == 0)) begin
      n_fail++;
      $display("FAIL %s: x=%h y=%h fc=%b sub=%b sc=%b ls=%b got r=%h v=%b z=%b exp r=%h v=%b z=%b",
               req, x, y, fc, sb, sc, ls, result_o, ovf_o, zero_o,
               e[31:0], e[32], e[31:0] == 0);
    end
  endtask

  function automatic string tag(input logic [1:0] fc);
    case (fc)
      2'b00: return "R7";
      2'b01: return "R6";
      2'b10: return "R3/R4";
      default: return "R2";
    endcase
  endfunction

  initial begin
    int w;
    w = 0;
    while (!done && w < 150000) begin @(posedge clk); w++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx, ry;
    logic [1:0]  rfc;
    x_i = 0; y_i = 0; shamt_i = 0; fclass_i = 0; sub_i = 0; shift_ctl_i = 0; logic_sel_i = 0;
    rst_ni = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1;
    // idle state: all-zero inputs give zero result, zero flag set (R9, R1)
    apply(0, 0, 0, 2'b00, 0, 3'b000, 2'b00, "R9 idle");
    // R4 overflow corners
    apply(32'h7fffffff, 32'h1, 0, 2'b10, 0, 0, 0, "R4 add pos ovf");
    apply(32'h80000000, 32'h1, 0, 2'b10, 1, 0, 0, "R4 sub neg ovf");
    apply(32'h80000000, 32'h80000000, 0, 2'b10, 0, 0, 0, "R4 add neg ovf, R9 zero");
    apply(32'h0, 32'h80000000, 0, 2'b10, 1, 0, 0, "R4 sub min ovf");
    apply(32'hffffffff, 32'h1, 0, 2'b10, 0, 0, 0, "R3 wrap no ovf, R9");
    apply(32'h5, 32'h5, 0, 2'b10, 1, 0, 0, "R3 sub equal, R9");
    // R6 with overflow inside the difference, both sub_i values
    apply(32'h80000000, 32'h1, 0, 2'b01, 0, 0, 0, "R6 min<1");
    apply(32'h7fffffff, 32'h80000000, 0, 2'b01, 1, 0, 0, "R6 max>min");
    apply(32'hfffffffe, 32'hffffffff, 0, 2'b01, 0, 0, 0, "R6 neg");
    apply(32'h3, 32'h3, 0, 2'b01, 1, 0, 0, "R6 equal, R9");
    // R5: operands that would overflow, non-arith classes
    apply(32'h7fffffff, 32'h7fffffff, 0, 2'b11, 0, 0, 2'b01, "R5 logic");
    apply(32'h7fffffff, 32'h7fffffff, 3, 2'b00, 0, 0, 0, "R5 shift");
    // R2 each function
    apply(32'h0, 32'h0, 0, 2'b11, 0, 0, 2'b11, "R2 nor zero");
    apply(32'hf0f0ff00, 32'h0ff0f0f0, 0, 2'b11, 0, 0, 2'b00, "R2 and");
    apply(32'hf0f0ff00, 32'h0ff0f0f0, 0, 2'b11, 0, 0, 2'b10, "R2 xor");
    apply(32'hffffffff, 32'h0, 0, 2'b11, 0, 0, 2'b11, "R2 nor ones, R9");
    // R7/R10 shift boundaries
    apply(0, 32'h80000000, 31, 2'b00, 0, 3'b011, 0, "R10 sra 31");
    apply(0, 32'h80000000, 31, 2'b00, 0, 3'b010, 0, "R10 srl 31");
    apply(0, 32'h00000001, 31, 2'b00, 0, 3'b000, 0, "R10 sll 31");
    apply(0, 32'h00000002, 31, 2'b00, 0, 3'b000, 0, "R10 sll out, R9");
    apply(0, 32'h9abcdef1, 0, 2'b00, 0, 3'b011, 0, "R10 amt0 sra");
    apply(0, 32'h9abcdef1, 0, 2'b00, 0, 3'b000, 0, "R10 amt0 sll");
    apply(0, 32'h9abcdef1, 13, 2'b00, 0, 3'b001, 0, "R7 pass");
    // R8 amount source
    apply(32'hffffffe4, 32'h80000000, 1, 2'b00, 0, 3'b111, 0, "R8 x source");
    apply(32'hffffffe4, 32'h80000000, 1, 2'b00, 0, 3'b011, 0, "R8 shamt source");
    apply(32'h00000008, 32'h000000ff, 0, 2'b00, 0, 3'b100, 0, "R8 x source sll");
    // R1 same operands across classes
    for (int c = 0; c < 4; c++)
      apply(32'h12345678, 32'h0000f00d, 4, 2'(c), 1, 3'b010, 2'b01, "R1 class sweep");
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      rx = $urandom;
      ry = $urandom;
      if (i % 7 == 0) ry = rx;
      if (i % 11 == 0) rx = {rx[31], 31'h7fffffff} ^ {32{rx[0]}};
      rfc = 2'($urandom);
      apply(rx, ry, 5'($urandom), rfc, 1'($urandom), 3'($urandom), 2'($urandom), tag(rfc));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule